// File: doc/BRIEF.md
# Chained Transfer Descriptor Loader

This block lets a transfer channel run a chain of segments with no processor help. It reads a descriptor from memory one word at a time over a plain read port. After the last word of that descriptor arrives, it loads the channel parameters toward an address generator in a single step. It then waits for the generator to report that the segment is done. When that report comes, it fetches the next descriptor, unless the loaded configuration asks it to halt.

Four descriptor layouts are supported, and a format code chooses one when the chain is started. The two-word ring layout forms a closed loop of identical ping-pong buffers. The four-word list layout carries a link, an address, a length and a configuration word. The one-word table layout gives only base addresses, which are read from consecutive words. The seven-word full layout sets every parameter, including the counts and strides for two dimensions. A field that a shorter layout does not carry keeps the value it last held.

Top module: `desc_seq_top`

## Requirements
- R1: After reset, busy, load and rd_req are 0 and all six parameter outputs are 0.
- R2: A start pulse while idle latches fmt and ptr. Word i of a descriptor is then requested at address ptr+i. At most one request is outstanding: rd_req lasts one cycle, and the next request follows only after rd_valid.
- R3: Format code 0 (ring) reads 2 words: word0 = link, word1 = address. Only p_addr changes. The next descriptor is read at the link.
- R4: Format code 1 (list) reads 4 words: link, address, length, config. These load p_addr, p_xcnt and p_cfg. The next descriptor is read at the link.
- R5: Format code 2 (table) reads 1 word, the address. The next descriptor is read at the current pointer + 1.
- R6: Format code 3 (full) reads 7 words: link, address, config, x count, x stride, y count, y stride. These load all six parameter outputs.
- R7: A parameter not carried by the active format keeps its previous value. This holds across descriptors and across separate starts.
- R8: The parameter outputs change only in the cycle after the last descriptor word is accepted. In that cycle load is high for exactly one cycle.
- R9: busy is high from the first request of a descriptor until the last word arrives. busy is low in the load cycle.
- R10: If p_cfg bit 0 (halt) is set when seg_done arrives, the block goes idle and issues no further request.
- R11: start is ignored unless the block is idle. seg_done is ignored unless a loaded segment is running.
- R12: While running with halt clear, a seg_done pulse starts the fetch of the next descriptor with no other stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a chain (idle only) |
| start_fmt | input | 2 | Descriptor format code |
| start_ptr | input | AW | Address of first descriptor |
| rd_req | output | 1 | Word read request |
| rd_addr | output | AW | Word address of the request |
| rd_data | input | 32 | Returned word |
| rd_valid | input | 1 | rd_data is valid |
| seg_done | input | 1 | Current segment finished |
| busy | output | 1 | Descriptor fetch in progress |
| load | output | 1 | Parameters updated this cycle |
| p_addr | output | 32 | Start address |
| p_xcnt | output | 32 | Inner count / length |
| p_xstride | output | 32 | Inner stride |
| p_ycnt | output | 32 | Outer count |
| p_ystride | output | 32 | Outer stride |
| p_cfg | output | 32 | Configuration word |

## Verification
Each format is started in turn. A ring of two descriptors is traversed until it wraps, which shows that the link is followed and not the next sequential address. A table is walked, which shows increment-by-one addressing and no link word. A list with a halting second entry and a full descriptor set different groups of fields. A later short descriptor then shows which fields are retained. Different memory latencies, plus start and seg_done pulses sent during a fetch, separate correct one-at-a-time fetching from designs that commit early or take a command at the wrong time.

// File: rtl/desc_seq_pkg.sv
package desc_seq_pkg;
    localparam int DW       = 32;
    localparam int MAXW     = 7;
    localparam int IW       = $clog2(MAXW);
    localparam int HALT_BIT = 0;

    typedef enum logic [1:0] {
        FMT_RING  = 2'd0,
        FMT_LIST  = 2'd1,
        FMT_TABLE = 2'd2,
        FMT_FULL  = 2'd3
    } fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_REQ, ST_WAIT, ST_LOAD, ST_RUN
    } st_e;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [DW-1:0] xcnt;
        logic [DW-1:0] xstride;
        logic [DW-1:0] ycnt;
        logic [DW-1:0] ystride;
        logic [DW-1:0] cfg;
    } chan_prm_t;

    function automatic logic [IW-1:0] last_word(fmt_e f);
        case (f)
            FMT_RING:  return IW'(1);
            FMT_LIST:  return IW'(3);
            FMT_TABLE: return IW'(0);
            default:   return IW'(MAXW - 1);
        endcase
    endfunction

    function automatic logic follows_link(fmt_e f);
        return f != FMT_TABLE;
    endfunction
endpackage

// File: rtl/desc_seq_ctrl.sv
module desc_seq_ctrl
    import desc_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  fmt_e          start_fmt,
    input  logic [AW-1:0] start_ptr,
    input  logic          rd_valid,
    input  logic          seg_done,
    input  logic          halt,
    input  logic [AW-1:0] next_ptr,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          load,
    output logic          cap,
    output logic          commit,
    output logic [IW-1:0] idx,
    output fmt_e          fmt,
    output logic [AW-1:0] ptr
);
    st_e state_q;
    logic last;

    assign last    = (idx == last_word(fmt));
    assign rd_req  = (state_q == ST_REQ);
    assign rd_addr = ptr + AW'(idx);
    assign busy    = (state_q == ST_REQ) || (state_q == ST_WAIT);
    assign load    = (state_q == ST_LOAD);
    assign cap     = (state_q == ST_WAIT) && rd_valid;
    assign commit  = cap && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fmt     <= FMT_RING;
            ptr     <= '0;
            idx     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    fmt     <= start_fmt;
                    ptr     <= start_ptr;
                    idx     <= '0;
                    state_q <= ST_REQ;
                end
                ST_REQ:  state_q <= ST_WAIT;
                ST_WAIT: if (rd_valid) begin
                    if (last) state_q <= ST_LOAD;
                    else begin
                        idx     <= idx + IW'(1);
                        state_q <= ST_REQ;
                    end
                end
                ST_LOAD: state_q <= ST_RUN;
                ST_RUN: if (seg_done) begin
                    if (halt) state_q <= ST_IDLE;
                    else begin
                        ptr     <= next_ptr;
                        idx     <= '0;
                        state_q <= ST_REQ;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_single_req_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);
    assert_req_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> busy);
    assert_load_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);
    assert_load_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);
    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && seg_done && halt) |=> (!rd_req && !busy));
    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start) |=> $stable(fmt));
endmodule

// File: rtl/desc_seq_stage.sv
module desc_seq_stage
    import desc_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic          commit,
    input  logic [IW-1:0] idx,
    input  fmt_e          fmt,
    input  logic [AW-1:0] ptr,
    input  logic [DW-1:0] rd_data,
    output chan_prm_t     prm,
    output logic [AW-1:0] next_ptr
);
    logic [DW-1:0] word_q [MAXW];
    logic [DW-1:0] view   [MAXW];
    chan_prm_t     prm_d;

    for (genvar g = 0; g < MAXW; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)                         word_q[g] <= '0;
            else if (cap && idx == IW'(g))   word_q[g] <= rd_data;
        end
        assign view[g] = (cap && idx == IW'(g)) ? rd_data : word_q[g];
    end

    always_comb begin
        prm_d = prm;
        case (fmt)
            FMT_RING:  prm_d.addr = view[1];
            FMT_LIST: begin
                prm_d.addr = view[1];
                prm_d.xcnt = view[2];
                prm_d.cfg  = view[3];
            end
            FMT_TABLE: prm_d.addr = view[0];
            default: begin
                prm_d.addr    = view[1];
                prm_d.cfg     = view[2];
                prm_d.xcnt    = view[3];
                prm_d.xstride = view[4];
                prm_d.ycnt    = view[5];
                prm_d.ystride = view[6];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prm      <= '0;
            next_ptr <= '0;
        end else if (commit) begin
            prm      <= prm_d;
            next_ptr <= follows_link(fmt) ? AW'(view[0]) : ptr + AW'(1);
        end
    end

    assert_prm_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(prm));
    assert_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
        cap |-> (idx <= last_word(fmt)));
endmodule

// File: rtl/desc_seq_top.sv
module desc_seq_top
    import desc_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    start_fmt,
    input  logic [AW-1:0] start_ptr,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic [31:0]   rd_data,
    input  logic          rd_valid,
    input  logic          seg_done,
    output logic          busy,
    output logic          load,
    output logic [31:0]   p_addr,
    output logic [31:0]   p_xcnt,
    output logic [31:0]   p_xstride,
    output logic [31:0]   p_ycnt,
    output logic [31:0]   p_ystride,
    output logic [31:0]   p_cfg
);
    logic          cap, commit;
    logic [IW-1:0] idx;
    fmt_e          fmt;
    logic [AW-1:0] ptr, next_ptr;
    chan_prm_t     prm;

    desc_seq_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .start_fmt(fmt_e'(start_fmt)),
        .start_ptr(start_ptr), .rd_valid(rd_valid), .seg_done(seg_done),
        .halt(prm.cfg[HALT_BIT]), .next_ptr(next_ptr), .rd_req(rd_req),
        .rd_addr(rd_addr), .busy(busy), .load(load), .cap(cap),
        .commit(commit), .idx(idx), .fmt(fmt), .ptr(ptr)
    );

    desc_seq_stage #(.AW(AW)) u_stage (
        .clk(clk), .rst(rst), .cap(cap), .commit(commit), .idx(idx),
        .fmt(fmt), .ptr(ptr), .rd_data(rd_data), .prm(prm),
        .next_ptr(next_ptr)
    );

    assign p_addr    = prm.addr;
    assign p_xcnt    = prm.xcnt;
    assign p_xstride = prm.xstride;
    assign p_ycnt    = prm.ycnt;
    assign p_ystride = prm.ystride;
    assign p_cfg     = prm.cfg;

    assert_out_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !load |-> $stable(p_addr));
endmodule

// File: tb/desc_seq_top_tb.sv
module desc_seq_top_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        start = 0;
    logic [1:0]  start_fmt = 0;
    logic [31:0] start_ptr = 0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic [31:0] rd_data = 0;
    logic        rd_valid = 0;
    logic        seg_done = 0;
    logic        busy, load;
    logic [31:0] p_addr, p_xcnt, p_xstride, p_ycnt, p_ystride, p_cfg;

    int checks = 0, failures = 0;
    logic [31:0] mem [0:63];
    int lat = 0;
    logic [31:0] req_log [0:15];
    int req_n = 0;
    bit pend = 0;
    int pwait = 0;
    logic [31:0] paddr = 0;

    always #5 clk = ~clk;

    desc_seq_top u_dut (
        .clk(clk), .rst(rst), .start(start), .start_fmt(start_fmt),
        .start_ptr(start_ptr), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .seg_done(seg_done),
        .busy(busy), .load(load), .p_addr(p_addr), .p_xcnt(p_xcnt),
        .p_xstride(p_xstride), .p_ycnt(p_ycnt), .p_ystride(p_ystride),
        .p_cfg(p_cfg)
    );

    always @(negedge clk) begin
        rd_valid = 0;
        if (pend) begin
            if (pwait == 0) begin
                rd_valid = 1;
                rd_data  = mem[paddr[5:0]];
                pend     = 0;
            end else pwait--;
        end
        if (rd_req) begin
            pend  = 1;
            paddr = rd_addr;
            pwait = lat;
            if (req_n < 16) req_log[req_n] = rd_addr;
            req_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (3) @(negedge clk);
        rst = 0; req_n = 0; lat = 0;
    endtask

    task automatic do_start(input logic [1:0] f, input logic [31:0] p);
        @(negedge clk);
        start = 1; start_fmt = f; start_ptr = p;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_load(input string req);
        int n = 0;
        while (!load && n < 200) begin @(negedge clk); n++; end
        chk(load, req, 32'(load), 1);
        chk(!busy, {req, " busy low at load (R9)"}, 32'(busy), 0);
    endtask

    task automatic pulse_seg();
        @(negedge clk); seg_done = 1;
        @(negedge clk); seg_done = 0;
    endtask

    task automatic test_reset();
        chk(!busy && !load && !rd_req, "R1 ctrl", {29'd0, busy, load, rd_req}, 0);
        chk(p_addr == 0 && p_xcnt == 0 && p_cfg == 0 && p_ycnt == 0
            && p_xstride == 0 && p_ystride == 0, "R1 params", p_addr, 0);
    endtask

    task automatic test_ring();
        mem[10] = 20; mem[11] = 32'hA000;
        mem[20] = 10; mem[21] = 32'hB000;
        do_reset();
        do_start(0, 10);
        chk(busy, "R9 busy during fetch", 32'(busy), 1);
        wait_load("R3 ring load");
        chk(p_addr == 32'hA000, "R3 ring addr", p_addr, 32'hA000);
        chk(req_n == 2 && req_log[0] == 10 && req_log[1] == 11, "R2 ring word addrs", req_log[1], 11);
        chk(p_xcnt == 0 && p_cfg == 0, "R3 ring other fields", p_xcnt, 0);
        pulse_seg();
        wait_load("R12 ring chain");
        chk(p_addr == 32'hB000 && req_log[2] == 20, "R3 ring follows link", req_log[2], 20);
        pulse_seg();
        wait_load("R12 ring wrap");
        chk(p_addr == 32'hA000 && req_log[4] == 10, "R3 ring wraps", req_log[4], 10);
    endtask

    task automatic test_list();
        mem[30] = 40; mem[31] = 32'h1111; mem[32] = 32'h64; mem[33] = 0;
        mem[40] = 99; mem[41] = 32'h2222; mem[42] = 32'h80; mem[43] = 1;
        do_reset(); lat = 3;
        do_start(1, 30);
        wait_load("R4 list load");
        chk(p_addr == 32'h1111 && p_xcnt == 32'h64 && p_cfg == 0, "R4 list fields", p_xcnt, 32'h64);
        chk(req_n == 4 && req_log[3] == 33, "R2 list four words", req_log[3], 33);
        repeat (3) @(negedge clk);
        chk(req_n == 4, "R12 no fetch before seg_done", req_n, 4);
        pulse_seg();
        repeat (6) @(negedge clk);
        chk(busy && p_addr == 32'h1111, "R8 params held mid fetch", p_addr, 32'h1111);
        wait_load("R12 list chain");
        chk(p_addr == 32'h2222 && p_xcnt == 32'h80 && p_cfg == 1 && req_log[4] == 40,
            "R4 list follows link", req_log[4], 40);
        pulse_seg();
        repeat (6) @(negedge clk);
        chk(req_n == 8 && !busy, "R10 halt stops chain", req_n, 8);
    endtask

    task automatic test_table();
        mem[50] = 32'hC000; mem[51] = 32'hD000;
        do_reset(); lat = 1;
        do_start(2, 50);
        wait_load("R5 table load");
        chk(p_addr == 32'hC000 && req_n == 1, "R5 table one word", p_addr, 32'hC000);
        pulse_seg();
        wait_load("R5 table next");
        chk(p_addr == 32'hD000 && req_log[1] == 51, "R5 table increments", req_log[1], 51);
    endtask

    task automatic test_full();
        mem[0] = 5; mem[1] = 32'hE000; mem[2] = 1; mem[3] = 16;
        mem[4] = 4; mem[5] = 8; mem[6] = 32'hFFFFFFC0;
        do_reset();
        do_start(3, 0);
        wait_load("R6 full load");
        chk(p_addr == 32'hE000 && p_cfg == 1 && p_xcnt == 16, "R6 full addr/cfg/xcnt", p_xcnt, 16);
        chk(p_xstride == 4 && p_ycnt == 8 && p_ystride == 32'hFFFFFFC0, "R6 full 2D", p_ystride, 32'hFFFFFFC0);
        chk(req_n == 7 && req_log[6] == 6, "R2 full seven words", req_log[6], 6);
        pulse_seg();
        repeat (4) @(negedge clk);
        chk(!busy && req_n == 7, "R10 full halt", req_n, 7);
        do_start(0, 10);
        wait_load("R7 ring after full");
        chk(p_addr == 32'hA000, "R7 ring addr", p_addr, 32'hA000);
        chk(p_xcnt == 16 && p_ycnt == 8 && p_xstride == 4 && p_cfg == 1, "R7 retained fields", p_xcnt, 16);
        pulse_seg();
        repeat (4) @(negedge clk);
        chk(!busy && req_n == 9, "R7 retained halt applies", req_n, 9);
    endtask

    task automatic test_ignore();
        do_reset(); lat = 3;
        do_start(0, 10);
        @(negedge clk);
        start = 1; start_fmt = 2; start_ptr = 50; seg_done = 1;
        @(negedge clk);
        start = 0; seg_done = 0;
        wait_load("R11 ignore load");
        chk(p_addr == 32'hA000 && req_n == 2 && req_log[0] == 10, "R11 start ignored when busy", p_addr, 32'hA000);
        repeat (4) @(negedge clk);
        chk(req_n == 2, "R11 early seg_done ignored", req_n, 2);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        test_reset();
        test_ring();
        test_list();
        test_table();
        test_full();
        test_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule